// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment value and an in-segment offset into a physical byte address for a 16-bit processor core with a 20-bit address space. The physical address is the segment shifted left by four bits plus the offset. For data accesses the offset is assembled from up to two pointer registers and an optional displacement. For instruction fetch the code segment and the instruction pointer are used directly.

The data path picks its segment in two steps. The stack segment is the default whenever the base pointer takes part in the offset, and the data segment is the default otherwise. A segment-override selection, when enabled, replaces that default. Register combinations outside the permitted set, and mode codes with no addressing operand, raise an illegal-mode flag. In that case the address output is forced to zero. All inputs are captured on the clock edge, and the results appear on the registered outputs one cycle later.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals segment × 16 plus the 16-bit offset, taken modulo 2^20, so a sum past 0xFFFFF wraps to the bottom of the space.
- R2: The data offset is the sum of the selected registers and the displacement, taken modulo 2^16 before the segment is added.
- R3: `reg_mask` selects the offset registers: bit0 BX, bit1 BP, bit2 SI, bit3 DI. Any single register and the pairs BX+SI, BX+DI, BP+SI and BP+DI are legal. A mask that sets both BX and BP, or both SI and DI, is illegal.
- R4: `disp_kind` selects the displacement: 0 none, 1 the low 8 bits of `disp` sign-extended, 2 all 16 bits of `disp`. Value 3 is illegal. Mask 0 with `disp_kind` 0 is illegal, and mask 0 with a displacement gives a displacement-only offset.
- R5: Without an override, a data access whose mask includes BP uses SS, and every other data access uses DS.
- R6: With `ovr_en` high, `ovr_sel` picks the segment for a data access, whatever the default would have been: 0 DS, 1 CS, 2 SS, 3 ES.
- R7: With `fetch` high, the address is CS × 16 + IP and `bad_mode` is 0. In this case `reg_mask`, `disp_kind`, `disp` and the override inputs have no effect.
- R8: An illegal data mode sets `bad_mode` to 1 and drives `phys_addr` to 0.
- R9: The outputs are registered. They reflect the inputs of the previous clock edge, and they read 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch | input | 1 | 1 selects instruction fetch, 0 a data access |
| reg_mask | input | 4 | Offset register select: bit0 BX, bit1 BP, bit2 SI, bit3 DI |
| disp_kind | input | 2 | Displacement form: 0 none, 1 sign-extended 8-bit, 2 16-bit, 3 illegal |
| disp | input | 16 | Displacement value |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment: 0 DS, 1 CS, 2 SS, 3 ES |
| bx | input | 16 | BX value |
| bp | input | 16 | BP value |
| si | input | 16 | SI value |
| di | input | 16 | DI value |
| ip | input | 16 | Instruction pointer |
| cs | input | 16 | Code segment |
| ds | input | 16 | Data segment |
| ss | input | 16 | Stack segment |
| es | input | 16 | Extra segment |
| phys_addr | output | 20 | Physical byte address |
| bad_mode | output | 1 | Illegal data addressing mode |

## Verification
The hardest cases to reach are those where two different wraps interact. In the first, the offset wraps at 2^16 while the segment term then carries the physical address across 2^20. In the second, a negative 8-bit displacement must pull the offset below zero. Reaching them requires choosing register values near the top of their range together with a large segment. The stimulus sets up BX, DI and CS for exactly these values and pairs them with a negative short displacement. It also issues a fetch while the mode, displacement and override inputs hold illegal or conflicting codes, so that an ignored input that leaked through would show up in the address.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   typedef enum logic [1:0] {
      SEG_DS = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_ES = 2'd3
   } seg_sel_e;

   typedef enum logic [1:0] {
      DISP_NONE  = 2'd0,
      DISP_SHORT = 2'd1,
      DISP_WIDE  = 2'd2,
      DISP_BAD   = 2'd3
   } disp_kind_e;

   localparam int unsigned NUM_PTR  = 4;
   localparam int unsigned PTR_BX   = 0;
   localparam int unsigned PTR_BP   = 1;
   localparam int unsigned PTR_SI   = 2;
   localparam int unsigned PTR_DI   = 3;
   localparam int unsigned NUM_SEG  = 4;
   localparam int unsigned SHORT_W  = 8;

endpackage

// File: rtl/seg_addr_offset.sv
module seg_addr_offset
   import seg_addr_pkg::*;
#(
   parameter int unsigned OFF_W = 16
) (
   input  logic [NUM_PTR-1:0] reg_mask,
   input  logic [1:0]         disp_kind,
   input  logic [OFF_W-1:0]   disp,
   input  logic [OFF_W-1:0]   bx,
   input  logic [OFF_W-1:0]   bp,
   input  logic [OFF_W-1:0]   si,
   input  logic [OFF_W-1:0]   di,
   output logic [OFF_W-1:0]   offset,
   output logic               illegal,
   output logic               uses_bp
);

   localparam int unsigned EXT_W = OFF_W - SHORT_W;

   logic [OFF_W-1:0] opnd [NUM_PTR];
   logic [OFF_W-1:0] term [NUM_PTR];
   logic [OFF_W-1:0] disp_ext;
   logic             pair_bad;
   logic             kind_bad;
   logic             empty_bad;

   assign opnd[PTR_BX] = bx;
   assign opnd[PTR_BP] = bp;
   assign opnd[PTR_SI] = si;
   assign opnd[PTR_DI] = di;

   for (genvar g = 0; g < NUM_PTR; g++) begin : g_term
      assign term[g] = reg_mask[g] ? opnd[g] : '0;
   end

   always_comb begin
      unique case (disp_kind_e'(disp_kind))
         DISP_SHORT: disp_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
         DISP_WIDE:  disp_ext = disp;
         default:    disp_ext = '0;
      endcase
   end

   always_comb begin
      offset = disp_ext;
      for (int i = 0; i < NUM_PTR; i++) begin
         offset = offset + term[i];
      end
   end

   assign pair_bad  = (reg_mask[PTR_BX] & reg_mask[PTR_BP]) |
                      (reg_mask[PTR_SI] & reg_mask[PTR_DI]);
   assign kind_bad  = (disp_kind == DISP_BAD);
   assign empty_bad = (reg_mask == '0) && (disp_kind == DISP_NONE);
   assign illegal   = pair_bad | kind_bad | empty_bad;
   assign uses_bp   = reg_mask[PTR_BP];

   // R4: the reserved displacement code must reach the illegal flag
   always_comb begin
      if (!$isunknown(disp_kind) && !$isunknown(illegal)) begin
         assert_kind_bad_R4: assert (disp_kind != DISP_BAD || illegal)
            else $error("reserved displacement code not flagged");
      end
   end

endmodule

// File: rtl/seg_addr_segsel.sv
module seg_addr_segsel
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic             fetch,
   input  logic             uses_bp,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_sel,
   input  logic [SEG_W-1:0] cs,
   input  logic [SEG_W-1:0] ds,
   input  logic [SEG_W-1:0] ss,
   input  logic [SEG_W-1:0] es,
   output logic [SEG_W-1:0] seg
);

   logic [NUM_SEG-1:0] grant;
   logic [SEG_W-1:0]   cand [NUM_SEG];
   logic [SEG_W-1:0]   part [NUM_SEG];
   seg_sel_e           pick;

   assign cand[SEG_DS] = ds;
   assign cand[SEG_CS] = cs;
   assign cand[SEG_SS] = ss;
   assign cand[SEG_ES] = es;

   always_comb begin
      if (fetch)         pick = SEG_CS;
      else if (ovr_en)   pick = seg_sel_e'(ovr_sel);
      else if (uses_bp)  pick = SEG_SS;
      else               pick = SEG_DS;
   end

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_grant
      assign grant[g] = (pick == seg_sel_e'(g));
      assign part[g]  = grant[g] ? cand[g] : '0;
   end

   always_comb begin
      seg = '0;
      for (int i = 0; i < NUM_SEG; i++) begin
         seg = seg | part[i];
      end
   end

   // R6: exactly one segment source may drive the result
   always_comb begin
      if (!$isunknown(grant)) begin
         assert_one_seg_R6: assert ($onehot(grant))
            else $error("segment grant not one-hot");
      end
   end

   // R5: BP-based data access without override takes the stack segment
   always_comb begin
      if (!$isunknown({fetch, ovr_en, uses_bp, grant})) begin
         assert_bp_stack_R5: assert (fetch || ovr_en || !uses_bp || grant[SEG_SS])
            else $error("BP access did not select stack segment");
      end
   end

endmodule

// File: rtl/seg_addr_combine.sv
module seg_addr_combine #(
   parameter int unsigned SEG_W  = 16,
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned SHIFT  = 4,
   parameter int unsigned PHYS_W = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  offset,
   output logic [PHYS_W-1:0] phys
);

   logic [PHYS_W-1:0] seg_term;
   logic [PHYS_W-1:0] off_term;

   assign seg_term = PHYS_W'(seg) << SHIFT;

   if (OFF_W < PHYS_W) begin : g_pad
      assign off_term = {{(PHYS_W-OFF_W){1'b0}}, offset};
   end else begin : g_trim
      assign off_term = offset[PHYS_W-1:0];
   end

   assign phys = seg_term + off_term;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W   = 16,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned SHIFT   = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fetch,
   input  logic [3:0]               reg_mask,
   input  logic [1:0]               disp_kind,
   input  logic [OFF_W-1:0]         disp,
   input  logic                     ovr_en,
   input  logic [1:0]               ovr_sel,
   input  logic [OFF_W-1:0]         bx,
   input  logic [OFF_W-1:0]         bp,
   input  logic [OFF_W-1:0]         si,
   input  logic [OFF_W-1:0]         di,
   input  logic [OFF_W-1:0]         ip,
   input  logic [SEG_W-1:0]         cs,
   input  logic [SEG_W-1:0]         ds,
   input  logic [SEG_W-1:0]         ss,
   input  logic [SEG_W-1:0]         es,
   output logic [SEG_W+SHIFT-1:0]   phys_addr,
   output logic                     bad_mode
);

   localparam int unsigned PHYS_W = SEG_W + SHIFT;

   initial begin
      assert_cfg_shift: assert (SHIFT > 0 && SHIFT <= SEG_W)
         else $error("SHIFT out of range");
      assert_cfg_off: assert (OFF_W > SHORT_W && OFF_W <= PHYS_W)
         else $error("OFF_W out of range");
   end

   logic [OFF_W-1:0]  data_off;
   logic              data_bad;
   logic              uses_bp;
   logic [OFF_W-1:0]  eff_off;
   logic [SEG_W-1:0]  seg;
   logic [PHYS_W-1:0] raw_phys;
   logic [PHYS_W-1:0] nxt_phys;
   logic              nxt_bad;

   seg_addr_offset #(.OFF_W(OFF_W)) u_offset (
      .reg_mask (reg_mask),
      .disp_kind(disp_kind),
      .disp     (disp),
      .bx       (bx),
      .bp       (bp),
      .si       (si),
      .di       (di),
      .offset   (data_off),
      .illegal  (data_bad),
      .uses_bp  (uses_bp)
   );

   seg_addr_segsel #(.SEG_W(SEG_W)) u_segsel (
      .fetch  (fetch),
      .uses_bp(uses_bp),
      .ovr_en (ovr_en),
      .ovr_sel(ovr_sel),
      .cs     (cs),
      .ds     (ds),
      .ss     (ss),
      .es     (es),
      .seg    (seg)
   );

   assign eff_off = fetch ? ip : data_off;

   seg_addr_combine #(
      .SEG_W (SEG_W),
      .OFF_W (OFF_W),
      .SHIFT (SHIFT),
      .PHYS_W(PHYS_W)
   ) u_combine (
      .seg   (seg),
      .offset(eff_off),
      .phys  (raw_phys)
   );

   assign nxt_bad  = !fetch && data_bad;
   assign nxt_phys = nxt_bad ? '0 : raw_phys;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            phys_addr <= '0;
            bad_mode  <= 1'b0;
         end else begin
            phys_addr <= nxt_phys;
            bad_mode  <= nxt_bad;
         end
      end

      assert_bad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         bad_mode |-> (phys_addr == '0));

      assert_fetch_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
         fetch |=> !bad_mode);

      assert_fetch_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
         fetch |=> (phys_addr == ((PHYS_W'($past(cs)) << SHIFT) + PHYS_W'($past(ip)))));

      assert_pair_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!fetch && ((reg_mask[PTR_BX] && reg_mask[PTR_BP]) ||
                     (reg_mask[PTR_SI] && reg_mask[PTR_DI]))) |=> bad_mode);
   end else begin : g_comb
      assign phys_addr = nxt_phys;
      assign bad_mode  = nxt_bad;
   end

endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch = 1'b1;
   logic [3:0]  reg_mask = '0;
   logic [1:0]  disp_kind = '0;
   logic [15:0] disp = '0;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_sel = '0;
   logic [15:0] bx = '0, bp = '0, si = '0, di = '0, ip = '0;
   logic [15:0] cs = '0, ds = '0, ss = '0, es = '0;
   logic [19:0] phys_addr;
   logic        bad_mode;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int          at;
      logic        bad;
      logic [19:0] addr;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   seg_addr_gen i_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .fetch(fetch), .reg_mask(reg_mask),
      .disp_kind(disp_kind), .disp(disp), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
      .bx(bx), .bp(bp), .si(si), .di(di), .ip(ip),
      .cs(cs), .ds(ds), .ss(ss), .es(es),
      .phys_addr(phys_addr), .bad_mode(bad_mode)
   );

   function automatic exp_t model(string tag);
      exp_t e;
      logic [15:0] off, sg, dx;
      bit bad;
      e.tag = tag;
      if (fetch) begin
         e.bad = 1'b0;
         e.addr = 20'({cs, 4'h0} + {4'h0, ip});
         return e;
      end
      bad = (reg_mask[0] && reg_mask[1]) || (reg_mask[2] && reg_mask[3]) ||
            (disp_kind == 2'd3) || (reg_mask == 4'd0 && disp_kind == 2'd0);
      case (disp_kind)
         2'd1: dx = {{8{disp[7]}}, disp[7:0]};
         2'd2: dx = disp;
         default: dx = 16'h0;
      endcase
      off = dx + (reg_mask[0] ? bx : 16'h0) + (reg_mask[1] ? bp : 16'h0) +
                 (reg_mask[2] ? si : 16'h0) + (reg_mask[3] ? di : 16'h0);
      if (ovr_en) begin
         case (ovr_sel)
            2'd0: sg = ds;
            2'd1: sg = cs;
            2'd2: sg = ss;
            default: sg = es;
         endcase
      end else begin
         sg = reg_mask[1] ? ss : ds;
      end
      e.bad = bad;
      e.addr = bad ? 20'h0 : 20'({sg, 4'h0} + {4'h0, off});
      return e;
   endfunction

   task automatic issue(input bit f, input logic [3:0] m, input logic [1:0] k,
                        input logic [15:0] d, input bit oe, input logic [1:0] os,
                        input string tag);
      exp_t e;
      @(posedge clk);
      #2;
      fetch = f; reg_mask = m; disp_kind = k; disp = d; ovr_en = oe; ovr_sel = os;
      e = model(tag);
      e.at = cyc;
      sb.push_back(e);
   endtask

   task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual bad=%0b addr=%05h expected bad=%0b addr=%05h",
                  tag, act[20], act[19:0], exp_v[20], exp_v[19:0]);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0 && sb[0].at < cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, {bad_mode, phys_addr}, {e.bad, e.addr});
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bx = 16'h1234; bp = 16'h8000; si = 16'h0011; di = 16'hFFFE;
      ip = 16'hFFF0; cs = 16'hF000; ds = 16'h2000; ss = 16'h3000; es = 16'h4000;
      repeat (3) @(posedge clk);
      #5;
      check("R9 reset state", {bad_mode, phys_addr}, 21'h0);
      @(posedge clk);
      #2;
      rst_n = 1'b1;

      // R7 fetch, R9 one-cycle latency
      issue(1, 4'd0, 2'd0, 16'h0, 0, 2'd0, "R7 fetch CS:IP");
      // R7 fetch ignores illegal mode and override
      issue(1, 4'b0011, 2'd3, 16'hFFFF, 1, 2'd3, "R7 fetch ignores mode");
      // R1 known value: DS=2000 BX=1234 -> 21234
      issue(0, 4'b0001, 2'd0, 16'h0, 0, 2'd0, "R1 BX only");
      // R4 displacement only, 16-bit
      issue(0, 4'b0000, 2'd2, 16'h0100, 0, 2'd0, "R4 disp16 only");
      // R4 8-bit negative displacement
      issue(0, 4'b0100, 2'd1, 16'hAB80, 0, 2'd0, "R4 SI+disp8 neg");
      // R3 legal pairs
      issue(0, 4'b0101, 2'd0, 16'h0, 0, 2'd0, "R3 BX+SI");
      issue(0, 4'b1001, 2'd2, 16'h0010, 0, 2'd0, "R3 BX+DI+disp16");
      // R5 BP pairs default to SS
      issue(0, 4'b0110, 2'd1, 16'h0005, 0, 2'd0, "R5 BP+SI SS default");
      issue(0, 4'b1010, 2'd0, 16'h0, 0, 2'd0, "R5 BP+DI SS default");
      issue(0, 4'b0010, 2'd0, 16'h0, 0, 2'd0, "R5 BP only");
      // R6 overrides
      issue(0, 4'b0010, 2'd0, 16'h0, 1, 2'd0, "R6 BP with DS override");
      issue(0, 4'b0001, 2'd0, 16'h0, 1, 2'd1, "R6 CS override");
      issue(0, 4'b0001, 2'd0, 16'h0, 1, 2'd2, "R6 SS override");
      issue(0, 4'b0001, 2'd0, 16'h0, 1, 2'd3, "R6 ES override");
      // R3 / R8 illegal pairs
      issue(0, 4'b0011, 2'd0, 16'h0, 0, 2'd0, "R3 BX+BP illegal");
      issue(0, 4'b1100, 2'd2, 16'h0040, 0, 2'd0, "R8 SI+DI illegal");
      issue(0, 4'b0001, 2'd3, 16'h0040, 0, 2'd0, "R4 reserved kind");
      issue(0, 4'b0000, 2'd0, 16'h0040, 1, 2'd2, "R4 empty mode");
      issue(0, 4'b1111, 2'd1, 16'h0001, 0, 2'd0, "R8 all regs");

      // wrap cases
      @(posedge clk);
      #2;
      bx = 16'hFFF0; di = 16'h0020; ds = 16'hFFFF; cs = 16'hFFFF; ip = 16'h0010;
      issue(0, 4'b1001, 2'd1, 16'h00F0, 0, 2'd0, "R2 offset wrap");
      issue(0, 4'b1001, 2'd0, 16'h0, 0, 2'd0, "R1 physical wrap");
      issue(1, 4'd0, 2'd0, 16'h0, 0, 2'd0, "R1 fetch wrap to 0");
      issue(0, 4'b0000, 2'd1, 16'h0080, 0, 2'd0, "R2 disp8 below zero");

      repeat (4) @(posedge clk);
      #8;
      if (sb.size() != 0) begin
         errors++;
         checks++;
         $display("FAIL R9: actual %0d pending expected 0 pending", sb.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule